// File: doc/BRIEF.md
# Debug Event Status Register

This block holds a 32-bit debug status word. Event lines from the debug comparators and trap logic set its bits. Software reads the word and clears bits by writing a mask in which each 1 clears a bit. An external debugger has its own port with full read and write access to every field. The block also drives a level debug-interrupt request.

The block supports resource sharing between software and the external debugger. An ownership mask marks each bit as owned by software or by the debugger. Ownership decides four things: which bits software sees, which bits software may clear, which bits a processor reset clears, and which bits can raise the interrupt.

A separate two-bit field records the most recent reset reason. A processor reset always loads this field, whatever the ownership. Bit positions follow the convention that vector bit `31-n` carries architectural bit `n`, so architectural bit 0 is the MSB. Every port is a plain control or status pin. Clear and write strobes take effect on the clock edge where they are high, and the block never stalls them.

Top module: `dbg_evt_status`

## Requirements
- R1: Implemented vector bits are 31..16, 15, 10, 9, 6, 5, 4, 2 and 1 (mask 0xFFFF8676). All other bits always read 0 on both read ports.
- R2: Power-on reset (`por_n` low) loads 0x1000_0000: reset-reason field [29:28] = 01, every other bit 0.
- R3: When `sw_clr_vld` is high, each 1 in `sw_clr_mask` clears the matching bit if software owns it, and each 0 leaves that bit unchanged. Software owns every bit when `ext_mode`=0. It owns the bits set in `own_sw` when `ext_mode`=1 and `share_idm`=1. It owns no bits when `ext_mode`=1 and `share_idm`=0.
- R4: `evt_set` bits set status bits only while `int_mode` or `ext_mode` is 1. Events never write the reset-reason field [29:28].
- R5: While sharing is active (`ext_mode`=1 and `share_idm`=1), `sw_rdata` shows 0 in every bit where `own_sw` is 0. Otherwise `sw_rdata` equals the full register. `dbg_rdata` always shows the full register.
- R6: `dbg_wr_vld` loads the register with `dbg_wdata` (limited to the implemented bits), whatever the ownership. It overrides a software clear in the same cycle.
- R7: `dbg_irq` is a combinational level. It is 1 exactly when `irq_en`=1, `int_mode`=1, and some software-owned interrupt-capable bit of the register is 1.
- R8: The reset-reason field [29:28] and the variable-length-encoding flag [4] never cause `dbg_irq`.
- R9: A processor reset (`cpu_rst` high at a clock edge) clears every software-owned bit, leaving debugger-owned bits unchanged. In the same edge it always loads [29:28] from `rst_cause`. A processor reset overrides events and writes in that cycle.
- R10: When an event sets a bit in the same cycle that a software clear or debugger write would make it 0, the bit ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cpu_rst | input | 1 | Synchronous processor reset strobe |
| rst_cause | input | 2 | Reset-reason code loaded by a processor reset |
| int_mode | input | 1 | Internal debug mode enabled |
| ext_mode | input | 1 | External debug mode enabled |
| share_idm | input | 1 | Internal-mode bit of the ownership register (enables sharing) |
| own_sw | input | 32 | Per-bit ownership, 1 = owned by software |
| irq_en | input | 1 | Debug interrupt enable |
| evt_set | input | 32 | Debug event set lines, one per status bit |
| sw_clr_vld | input | 1 | Software clear strobe |
| sw_clr_mask | input | 32 | Software clear mask (1 clears) |
| sw_rdata | output | 32 | Ownership-masked software read value |
| dbg_wr_vld | input | 1 | Debugger write strobe |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Unmasked debugger read value |
| dbg_irq | output | 1 | Debug interrupt request (level) |

## Verification
The bench targets the ownership corners, each of which fails in a visible way. A design that ignores ownership would let software clear debugger-owned bits, or would expose them on `sw_rdata`, while sharing is active. A design that ignores the reset-reason rule would leave the old code in place after a processor reset under external mode. The bench also drives a set and a clear into the same bit in one cycle: a design with the wrong priority drops that event. A design that forgets the exclusion mask raises `dbg_irq` when only the reset-reason field or the encoding flag is set.

// File: rtl/dbg_evt_pkg.sv
package dbg_evt_pkg;
  localparam int unsigned STAT_W = 32;
  localparam int unsigned CAUSE_W = 2;
  localparam int unsigned CAUSE_LO = 28;
  localparam logic [STAT_W-1:0] IMPL_MASK = 32'hFFFF_8676;
  localparam logic [STAT_W-1:0] RESET_VAL = 32'h1000_0000;
  localparam logic [STAT_W-1:0] CAUSE_MASK = 32'h3000_0000;
  localparam logic [STAT_W-1:0] IRQ_EXCL = 32'h3000_0010;
endpackage

// File: rtl/dbg_evt_own.sv
module dbg_evt_own
  import dbg_evt_pkg::*;
(
  input  logic              ext_mode,
  input  logic              share_idm,
  input  logic [STAT_W-1:0] own_sw,
  output logic [STAT_W-1:0] sw_own,
  output logic [STAT_W-1:0] rd_mask
);
  logic sharing;
  assign sharing = ext_mode & share_idm;

  always_comb begin
    if (!ext_mode)    sw_own = '1;
    else if (sharing) sw_own = own_sw;
    else              sw_own = '0;
    rd_mask = sharing ? own_sw : '1;
  end
endmodule

// File: rtl/dbg_evt_cells.sv
module dbg_evt_cells
  import dbg_evt_pkg::*;
#(
  parameter logic [STAT_W-1:0] IMPL = IMPL_MASK,
  parameter logic [STAT_W-1:0] RST  = RESET_VAL
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               cpu_rst,
  input  logic [CAUSE_W-1:0] rst_cause,
  input  logic               set_en,
  input  logic [STAT_W-1:0]  evt_set,
  input  logic [STAT_W-1:0]  sw_own,
  input  logic               sw_clr_vld,
  input  logic [STAT_W-1:0]  sw_clr_mask,
  input  logic               dbg_wr_vld,
  input  logic [STAT_W-1:0]  dbg_wdata,
  output logic [STAT_W-1:0]  stat_q
);
  localparam int unsigned CAUSE_HI = CAUSE_LO + CAUSE_W - 1;

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (!IMPL[i]) begin : g_rsvd
      assign stat_q[i] = 1'b0;
    end else if (i >= CAUSE_LO && i <= CAUSE_HI) begin : g_cause
      logic q;
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)          q <= RST[i];
        else if (cpu_rst)    q <= rst_cause[i-CAUSE_LO];
        else if (dbg_wr_vld) q <= dbg_wdata[i];
        else if (sw_clr_vld && sw_clr_mask[i] && sw_own[i]) q <= 1'b0;
      end
      assign stat_q[i] = q;
    end else begin : g_stat
      logic q;
      logic kept;
      always_comb begin
        if (dbg_wr_vld)      kept = dbg_wdata[i];
        else if (sw_clr_vld) kept = q & ~(sw_clr_mask[i] & sw_own[i]);
        else                 kept = q;
      end
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)       q <= RST[i];
        else if (cpu_rst) q <= q & ~sw_own[i];
        else              q <= kept | (set_en & evt_set[i]);
      end
      assign stat_q[i] = q;
    end
  end
endmodule

// File: rtl/dbg_evt_irq.sv
module dbg_evt_irq
  import dbg_evt_pkg::*;
#(
  parameter logic [STAT_W-1:0] EXCL = IRQ_EXCL
) (
  input  logic [STAT_W-1:0] stat_q,
  input  logic [STAT_W-1:0] sw_own,
  input  logic              irq_en,
  input  logic              int_mode,
  output logic              dbg_irq
);
  assign dbg_irq = irq_en & int_mode & (|(stat_q & sw_own & ~EXCL));
endmodule

// File: rtl/dbg_evt_status.sv
module dbg_evt_status
  import dbg_evt_pkg::*;
#(
  parameter logic [STAT_W-1:0] IMPL = IMPL_MASK,
  parameter logic [STAT_W-1:0] RST  = RESET_VAL,
  parameter logic [STAT_W-1:0] EXCL = IRQ_EXCL
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               cpu_rst,
  input  logic [CAUSE_W-1:0] rst_cause,
  input  logic               int_mode,
  input  logic               ext_mode,
  input  logic               share_idm,
  input  logic [STAT_W-1:0]  own_sw,
  input  logic               irq_en,
  input  logic [STAT_W-1:0]  evt_set,
  input  logic               sw_clr_vld,
  input  logic [STAT_W-1:0]  sw_clr_mask,
  output logic [STAT_W-1:0]  sw_rdata,
  input  logic               dbg_wr_vld,
  input  logic [STAT_W-1:0]  dbg_wdata,
  output logic [STAT_W-1:0]  dbg_rdata,
  output logic               dbg_irq
);
  logic [STAT_W-1:0] sw_own;
  logic [STAT_W-1:0] rd_mask;
  logic [STAT_W-1:0] stat_q;

  dbg_evt_own u_own (
    .ext_mode (ext_mode),
    .share_idm(share_idm),
    .own_sw   (own_sw),
    .sw_own   (sw_own),
    .rd_mask  (rd_mask)
  );

  dbg_evt_cells #(.IMPL(IMPL), .RST(RST)) u_cells (
    .clk        (clk),
    .por_n      (por_n),
    .cpu_rst    (cpu_rst),
    .rst_cause  (rst_cause),
    .set_en     (int_mode | ext_mode),
    .evt_set    (evt_set),
    .sw_own     (sw_own),
    .sw_clr_vld (sw_clr_vld),
    .sw_clr_mask(sw_clr_mask),
    .dbg_wr_vld (dbg_wr_vld),
    .dbg_wdata  (dbg_wdata),
    .stat_q     (stat_q)
  );

  dbg_evt_irq #(.EXCL(EXCL)) u_irq (
    .stat_q  (stat_q),
    .sw_own  (sw_own),
    .irq_en  (irq_en),
    .int_mode(int_mode),
    .dbg_irq (dbg_irq)
  );

  assign dbg_rdata = stat_q;
  assign sw_rdata  = stat_q & rd_mask;
endmodule

// File: rtl/dbg_evt_status_chk.sv
module dbg_evt_status_chk
  import dbg_evt_pkg::*;
(
  input logic               clk,
  input logic               por_n,
  input logic               cpu_rst,
  input logic [CAUSE_W-1:0] rst_cause,
  input logic               int_mode,
  input logic               ext_mode,
  input logic               share_idm,
  input logic [STAT_W-1:0]  own_sw,
  input logic               irq_en,
  input logic [STAT_W-1:0]  evt_set,
  input logic               sw_clr_vld,
  input logic [STAT_W-1:0]  sw_clr_mask,
  input logic [STAT_W-1:0]  sw_rdata,
  input logic               dbg_wr_vld,
  input logic [STAT_W-1:0]  dbg_wdata,
  input logic [STAT_W-1:0]  dbg_rdata,
  input logic               dbg_irq
);
  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!por_n)
    ((dbg_rdata | sw_rdata) & ~IMPL_MASK) == '0);

  a_r3_clear_owned: assert property (@(posedge clk) disable iff (!por_n)
    (sw_clr_vld && !cpu_rst && !dbg_wr_vld && !ext_mode && !int_mode)
    |=> ((dbg_rdata & $past(sw_clr_mask)) == '0));

  a_r4_event_sets: assert property (@(posedge clk) disable iff (!por_n)
    (!cpu_rst && (int_mode || ext_mode))
    |=> ((dbg_rdata & $past(evt_set & IMPL_MASK & ~CAUSE_MASK))
         == $past(evt_set & IMPL_MASK & ~CAUSE_MASK)));

  a_r5_read_mask: assert property (@(posedge clk) disable iff (!por_n)
    (ext_mode && share_idm) |-> ((sw_rdata & ~own_sw) == '0));

  a_r6_dbg_write: assert property (@(posedge clk) disable iff (!por_n)
    (dbg_wr_vld && !cpu_rst && !int_mode && !ext_mode)
    |=> (dbg_rdata == $past(dbg_wdata & IMPL_MASK)));

  a_r7_irq_gate: assert property (@(posedge clk) disable iff (!por_n)
    dbg_irq |-> (irq_en && int_mode));

  a_r8_irq_excl: assert property (@(posedge clk) disable iff (!por_n)
    ((dbg_rdata & ~IRQ_EXCL) == '0) |-> !dbg_irq);

  a_r9_cause_load: assert property (@(posedge clk) disable iff (!por_n)
    cpu_rst |=> (dbg_rdata[CAUSE_LO+:CAUSE_W] == $past(rst_cause)));
endmodule

bind dbg_evt_status dbg_evt_status_chk u_chk (
  .clk(clk), .por_n(por_n), .cpu_rst(cpu_rst), .rst_cause(rst_cause),
  .int_mode(int_mode), .ext_mode(ext_mode), .share_idm(share_idm),
  .own_sw(own_sw), .irq_en(irq_en), .evt_set(evt_set),
  .sw_clr_vld(sw_clr_vld), .sw_clr_mask(sw_clr_mask), .sw_rdata(sw_rdata),
  .dbg_wr_vld(dbg_wr_vld), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
  .dbg_irq(dbg_irq)
);

// File: tb/sim_dbg_evt_status.sv
module sim_dbg_evt_status;
  localparam logic [31:0] IMPL  = 32'hFFFF_8676;
  localparam logic [31:0] CAUSE = 32'h3000_0000;
  localparam logic [31:0] EXCL  = 32'h3000_0010;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        por_n = 1'b0, cpu_rst = 1'b0, int_mode = 1'b0, ext_mode = 1'b0;
  logic        share_idm = 1'b0, irq_en = 1'b0, sw_clr_vld = 1'b0, dbg_wr_vld = 1'b0;
  logic [1:0]  rst_cause = 2'b00;
  logic [31:0] own_sw = '0, evt_set = '0, sw_clr_mask = '0, dbg_wdata = '0;
  logic [31:0] sw_rdata, dbg_rdata;
  logic        dbg_irq;

  dbg_evt_status u0 (
    .clk(clk), .por_n(por_n), .cpu_rst(cpu_rst), .rst_cause(rst_cause),
    .int_mode(int_mode), .ext_mode(ext_mode), .share_idm(share_idm),
    .own_sw(own_sw), .irq_en(irq_en), .evt_set(evt_set),
    .sw_clr_vld(sw_clr_vld), .sw_clr_mask(sw_clr_mask), .sw_rdata(sw_rdata),
    .dbg_wr_vld(dbg_wr_vld), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
    .dbg_irq(dbg_irq)
  );

  typedef struct {
    string       tag;
    logic [31:0] dbg;
    logic [31:0] sw;
    logic        irq;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0, errors = 0;
  bit          done = 0;
  logic [31:0] m = 32'h1000_0000;

  // reference model built from the requirements
  task automatic step(string tag);
    logic [31:0] own, nxt;
    exp_t e;
    own = !ext_mode ? '1 : (share_idm ? own_sw : '0);
    nxt = m;
    if (cpu_rst) begin
      nxt = m & ~(own & ~CAUSE);
      nxt[29:28] = rst_cause;
    end else begin
      if (dbg_wr_vld)      nxt = dbg_wdata & IMPL;
      else if (sw_clr_vld) nxt = m & ~(sw_clr_mask & own);
      if (int_mode || ext_mode) nxt = nxt | (evt_set & IMPL & ~CAUSE);
    end
    m = nxt;
    e.tag = tag;
    e.dbg = m;
    e.sw  = m & ((ext_mode && share_idm) ? own_sw : '1);
    e.irq = irq_en & int_mode & (|(m & own & ~EXCL));
    sb.push_back(e);
    @(posedge clk);
    #2;
    cpu_rst = 0; sw_clr_vld = 0; dbg_wr_vld = 0; evt_set = '0;
  endtask

  // monitor: compares results as they appear after each edge
  always @(posedge clk) begin
    #1;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (dbg_rdata !== e.dbg || sw_rdata !== e.sw || dbg_irq !== e.irq) begin
        errors++;
        $display("FAIL %s: dbg=%h sw=%h irq=%b expected dbg=%h sw=%h irq=%b",
                 e.tag, dbg_rdata, sw_rdata, dbg_irq, e.dbg, e.sw, e.irq);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 por_n = 1;
    step("R2 reset value");
    evt_set = 32'h8000_0000;
    step("R4 event ignored with modes off");
    int_mode = 1; evt_set = '1;
    step("R1 R4 all events set, reserved zero");
    irq_en = 1;
    step("R7 irq raised");
    sw_clr_vld = 1; sw_clr_mask = ~EXCL;
    step("R8 only excluded bits left, no irq");
    sw_clr_vld = 1; sw_clr_mask = '1;
    step("R3 clear all");
    sw_clr_vld = 1; sw_clr_mask = 32'h0800_0000; evt_set = 32'h0800_0000;
    step("R10 set beats clear");
    dbg_wr_vld = 1; dbg_wdata = '1; sw_clr_vld = 1; sw_clr_mask = '1;
    step("R6 debugger write beats clear");
    dbg_wr_vld = 1; dbg_wdata = '0; evt_set = 32'h0000_0400;
    step("R10 set beats debugger write");
    dbg_wr_vld = 1; dbg_wdata = '1;
    step("R6 debugger write all");
    ext_mode = 1; share_idm = 1; own_sw = 32'h0000_FFFF;
    step("R5 shared read mask");
    sw_clr_vld = 1; sw_clr_mask = '1;
    step("R3 shared clear owned only");
    step("R7 no irq from debugger-owned bits");
    evt_set = 32'h0000_8000;
    step("R7 irq from software-owned bit");
    cpu_rst = 1; rst_cause = 2'b10; evt_set = 32'h0000_0200;
    step("R9 processor reset under sharing");
    share_idm = 0;
    sw_clr_vld = 1; sw_clr_mask = '1;
    step("R3 no clear without sharing");
    ext_mode = 0; cpu_rst = 1; rst_cause = 2'b11;
    step("R9 processor reset, external mode off");
    #1 por_n = 0;
    m = 32'h1000_0000;
    #5 por_n = 1;
    step("R2 power-on reset mid-run");
    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule